// File: doc/BRIEF.md
# Handshaking Parallel Port Controller

This block is one parallel port of a general-purpose interface adapter. Each pin can be an input or an output, chosen bit by bit. Two control lines go with the port. CA1 is an input that reacts only to edges, and the active edge can be programmed. CA2 can be an edge-triggered input, or an output that does a full handshake, gives a single-cycle strobe, or holds a fixed level. When input latching is on, the port value that the host reads is captured at the moment a CA1 event is flagged. It stays captured until that flag is cleared.

The host reaches the block through a small synchronous register bus: chip select, a 2-bit register select, a read/write line and a data bus. The port data appears at two addresses. The main address has handshake side effects: it clears flags and drives CA2. The alias address gives the same data with no side effects at all. The CA1 and CA2 flags are kept inside the block because they control the latch and the clearing rules. Their set pulses and levels go out to a separate interrupt block, and that interrupt block can clear either flag through an acknowledge input.

Top module: `hspp_port`

## Requirements
- R1: After reset, the direction and control registers read 0 and all pins are inputs (`pa_oe_o` = 0). CA2 is in mode 0, with `ca2_oe_o` = 0, and both flags are 0.
- R2: `pa_oe_o` equals the direction register and `pa_o` equals the output register. For each bit of a port data read, the output register bit is returned if the direction bit is 1. Otherwise the pin bit sampled one clock earlier is returned.
- R3: Control bit 0 selects the active CA1 edge: 0 means falling, 1 means rising. After the pin changes, the next rising clock edge raises `ca1_set_o` for exactly one cycle. The edge after that sets `ca1_flag_o`. The inactive edge sets nothing.
- R4: A read or write at register 0 (port data with handshake) clears the CA1 flag. So does `flag_clr_i[0]`. If a new CA1 event arrives in the same cycle as a clear, the set wins.
- R5: When control bit 4 is 1 (latch on) and the CA1 flag is set, port reads return the pins sampled when the CA1 edge was seen. This holds until the flag clears, whatever the pins do in the meantime.
- R6: CA2 mode is control bits 3:1. Mode 0 flags a falling CA2 edge and mode 2 flags a rising one. The inactive edge is ignored. An access at register 0 clears the flag.
- R7: Modes 1 (falling) and 3 (rising) set the CA2 flag in the same way, but an access at register 0 leaves it set. Only `flag_clr_i[1]` clears it.
- R8: In mode 4, CA2 is a handshake output. It drives high until an access at register 0, then low from the next cycle. It returns high one cycle after the active CA1 edge is seen.
- R9: In mode 5, CA2 drives low for exactly one cycle after each access at register 0, and is high otherwise.
- R10: Mode 6 holds CA2 low and mode 7 holds it high. `ca2_oe_o` is 1 in modes 4 to 7 and 0 in modes 0 to 3.
- R11: Register 3 reads and writes the same port data as register 0. It never clears a flag and never changes CA2.
- R12: In the output modes (4 to 7), edges on the CA2 pin never set the CA2 flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_i | input | 1 | Chip select; each cycle with it high is one access |
| rw_i | input | 1 | 1 = read, 0 = write |
| rs_i | input | 2 | Register select: 0 data with handshake, 1 direction, 2 control, 3 data without handshake |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data (combinational, 0 when not reading) |
| pa_i | input | W | Port pin inputs |
| pa_o | output | W | Port output register |
| pa_oe_o | output | W | Per-bit output enable (direction register) |
| ca1_i | input | 1 | CA1 control input |
| ca2_i | input | 1 | CA2 pin input |
| ca2_o | output | 1 | CA2 output value |
| ca2_oe_o | output | 1 | CA2 output enable |
| flag_clr_i | input | 2 | Flag clear from the interrupt block: bit 0 CA1, bit 1 CA2 |
| ca1_set_o | output | 1 | One-cycle CA1 flag set request |
| ca2_set_o | output | 1 | One-cycle CA2 flag set request |
| ca1_flag_o | output | 1 | CA1 flag level |
| ca2_flag_o | output | 1 | CA2 flag level |

## Verification
The bench sweeps the direction, output and pin values over many patterns and checks every CA2 mode in turn. In each input mode it sends the inactive edge before the active one. A design with the polarity reversed would set the flag on the wrong edge and be caught. The bench also reads the port through both data addresses while a flag is set. A design that lets the alias address clear flags or pull CA2 low would lose the flag or show a spurious strobe. For the latch, the pins change right after the CA1 edge. A design that captures one cycle late, or re-captures while the flag is already set, would return the second value instead of the first.

// File: rtl/hspp_pkg.sv
package hspp_pkg;

  typedef enum logic [1:0] {
    SEL_DATA_HS = 2'd0,
    SEL_DIR     = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_DATA_Q  = 2'd3
  } reg_sel_e;

  // CA2 mode: bit2 = output, bit1 = rising polarity (input), bit0 = independent
  typedef enum logic [2:0] {
    C2_IN_FALL  = 3'd0,
    C2_IND_FALL = 3'd1,
    C2_IN_RISE  = 3'd2,
    C2_IND_RISE = 3'd3,
    C2_HANDSHK  = 3'd4,
    C2_STROBE   = 3'd5,
    C2_FIX_LO   = 3'd6,
    C2_FIX_HI   = 3'd7
  } ca2_mode_e;

  localparam int CTRL_W      = 5;
  localparam int CB_CA1_POS  = 0;
  localparam int CB_MODE_LO  = 1;
  localparam int CB_MODE_HI  = 3;
  localparam int CB_LATCH    = 4;

  function automatic logic pick_edge(input logic rising_sel, input logic rise, input logic fall);
    return rising_sel ? rise : fall;
  endfunction

  function automatic logic mode_is_input(input ca2_mode_e m);
    return ~m[2];
  endfunction

  function automatic logic mode_cleared_by_access(input ca2_mode_e m);
    return ~m[2] & ~m[0];
  endfunction

  // next value of a set/clear flag, set has priority
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/hspp_edge.sv
module hspp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic smp_q;
  logic prv_q;

  // during reset both stages track the pin so release sees no edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q <= pin_i;
      prv_q <= pin_i;
    end else begin
      smp_q <= pin_i;
      prv_q <= smp_q;
    end
  end

  assign rise_o = smp_q & ~prv_q;
  assign fall_o = ~smp_q & prv_q;
endmodule

// File: rtl/hspp_datapath.sv
module hspp_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pa_i,
  input  logic [W-1:0] wdata_i,
  input  logic         dir_we_i,
  input  logic         out_we_i,
  input  logic         capture_i,
  input  logic         hold_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] port_rd_o
);
  logic [W-1:0] dir_q;
  logic [W-1:0] out_q;
  logic [W-1:0] pin_q;
  logic [W-1:0] lat_q;
  logic [W-1:0] in_view;

  function automatic logic [W-1:0] blend(input logic [W-1:0] dir,
                                         input logic [W-1:0] drv,
                                         input logic [W-1:0] inp);
    return (drv & dir) | (inp & ~dir);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      pin_q <= '0;
      lat_q <= '0;
    end else begin
      pin_q <= pa_i;
      if (dir_we_i)  dir_q <= wdata_i;
      if (out_we_i)  out_q <= wdata_i;
      if (capture_i) lat_q <= pin_q;
    end
  end

  assign in_view   = hold_i ? lat_q : pin_q;
  assign port_rd_o = blend(dir_q, out_q, in_view);
  assign dir_o     = dir_q;
  assign out_o     = out_q;
  assign lat_o     = lat_q;
endmodule

// File: rtl/hspp_ca2_ctl.sv
module hspp_ca2_ctl
  import hspp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ca2_mode_e mode_i,
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      data_acc_i,
  input  logic      ca1_edge_i,
  input  logic      clr_i,
  output logic      ca2_o,
  output logic      ca2_oe_o,
  output logic      set_o,
  output logic      flag_o
);
  logic flag_q;
  logic hs_q;
  logic strobe_q;
  logic acc_clr;

  assign set_o   = mode_is_input(mode_i) & pick_edge(mode_i[1], rise_i, fall_i);
  assign acc_clr = mode_cleared_by_access(mode_i) & data_acc_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      hs_q     <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      flag_q   <= flag_next(flag_q, set_o, acc_clr | clr_i);
      strobe_q <= data_acc_i & (mode_i == C2_STROBE);
      if (mode_i != C2_HANDSHK) hs_q <= 1'b1;
      else if (data_acc_i)      hs_q <= 1'b0;
      else if (ca1_edge_i)      hs_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (mode_i)
      C2_HANDSHK: ca2_o = hs_q;
      C2_STROBE:  ca2_o = ~strobe_q;
      C2_FIX_LO:  ca2_o = 1'b0;
      default:    ca2_o = 1'b1;
    endcase
  end

  assign ca2_oe_o = ~mode_is_input(mode_i);
  assign flag_o   = flag_q;
endmodule

// File: rtl/hspp_port.sv
module hspp_port
  import hspp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_i,
  input  logic         rw_i,
  input  logic [1:0]   rs_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pa_i,
  output logic [W-1:0] pa_o,
  output logic [W-1:0] pa_oe_o,
  input  logic         ca1_i,
  input  logic         ca2_i,
  output logic         ca2_o,
  output logic         ca2_oe_o,
  input  logic [1:0]   flag_clr_i,
  output logic         ca1_set_o,
  output logic         ca2_set_o,
  output logic         ca1_flag_o,
  output logic         ca2_flag_o
);
  localparam int PAD_W = W - CTRL_W;

  reg_sel_e          sel;
  logic [CTRL_W-1:0] ctrl_q;
  ca2_mode_e         ca2_mode;
  logic              latch_en;

  // named internal events
  logic data_acc;
  logic quiet_acc;
  logic ctrl_wr;
  logic dir_wr;
  logic out_wr;
  logic ca1_edge;
  logic ca1_rise, ca1_fall;
  logic ca2_rise, ca2_fall;
  logic ca1_flag_q;
  logic lat_capture;
  logic lat_hold;

  logic [W-1:0] dir_v, out_v, lat_q, port_rd;

  assign sel       = reg_sel_e'(rs_i);
  assign data_acc  = cs_i & (sel == SEL_DATA_HS);
  assign quiet_acc = cs_i & (sel == SEL_DATA_Q);
  assign ctrl_wr   = cs_i & ~rw_i & (sel == SEL_CTRL);
  assign dir_wr    = cs_i & ~rw_i & (sel == SEL_DIR);
  assign out_wr    = (data_acc | quiet_acc) & ~rw_i;

  assign ca2_mode  = ca2_mode_e'(ctrl_q[CB_MODE_HI:CB_MODE_LO]);
  assign latch_en  = ctrl_q[CB_LATCH];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  hspp_edge ca1_det_i (
    .clk(clk), .rst_n(rst_n), .pin_i(ca1_i), .rise_o(ca1_rise), .fall_o(ca1_fall)
  );

  hspp_edge ca2_det_i (
    .clk(clk), .rst_n(rst_n), .pin_i(ca2_i), .rise_o(ca2_rise), .fall_o(ca2_fall)
  );

  assign ca1_edge = pick_edge(ctrl_q[CB_CA1_POS], ca1_rise, ca1_fall);

  always_ff @(posedge clk) begin
    if (!rst_n) ca1_flag_q <= 1'b0;
    else        ca1_flag_q <= flag_next(ca1_flag_q, ca1_edge, data_acc | flag_clr_i[0]);
  end

  assign lat_capture = ca1_edge & latch_en & ~ca1_flag_q;
  assign lat_hold    = latch_en & ca1_flag_q;

  hspp_datapath #(.W(W)) dp_i (
    .clk(clk), .rst_n(rst_n), .pa_i(pa_i), .wdata_i(wdata_i),
    .dir_we_i(dir_wr), .out_we_i(out_wr),
    .capture_i(lat_capture), .hold_i(lat_hold),
    .dir_o(dir_v), .out_o(out_v), .lat_o(lat_q), .port_rd_o(port_rd)
  );

  hspp_ca2_ctl ca2_i_ctl (
    .clk(clk), .rst_n(rst_n), .mode_i(ca2_mode),
    .rise_i(ca2_rise), .fall_i(ca2_fall),
    .data_acc_i(data_acc), .ca1_edge_i(ca1_edge), .clr_i(flag_clr_i[1]),
    .ca2_o(ca2_o), .ca2_oe_o(ca2_oe_o), .set_o(ca2_set_o), .flag_o(ca2_flag_o)
  );

  always_comb begin
    rdata_o = '0;
    if (cs_i && rw_i) begin
      unique case (sel)
        SEL_DATA_HS, SEL_DATA_Q: rdata_o = port_rd;
        SEL_DIR:                 rdata_o = dir_v;
        default:                 rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      endcase
    end
  end

  assign pa_o       = out_v;
  assign pa_oe_o    = dir_v;
  assign ca1_set_o  = ca1_edge;
  assign ca1_flag_o = ca1_flag_q;
endmodule

// File: rtl/hspp_port_chk.sv
module hspp_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         data_acc,
  input logic         quiet_acc,
  input logic         ctrl_wr,
  input logic [2:0]   ca2_mode,
  input logic [1:0]   flag_clr_i,
  input logic         ca1_set_o,
  input logic         ca2_set_o,
  input logic         ca1_flag_o,
  input logic         ca2_flag_o,
  input logic         ca2_o,
  input logic         ca2_oe_o,
  input logic [W-1:0] lat_q
);
  AST_CA1_SET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ca1_set_o |=> ca1_flag_o); // R3
  AST_CA1_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ca1_set_o) |=> !ca1_flag_o); // R4
  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ca1_flag_o |=> $stable(lat_q)); // R5
  AST_CA2_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ca2_mode == 3'd0 || ca2_mode == 3'd2) && data_acc && !ca2_set_o) |=> !ca2_flag_o); // R6
  AST_CA2_INDEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ca2_flag_o && (ca2_mode == 3'd1 || ca2_mode == 3'd3) && !flag_clr_i[1] && !ctrl_wr)
      |=> ca2_flag_o); // R7
  AST_HANDSHAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ca2_mode == 3'd4 && data_acc) |=> !ca2_o); // R8
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ca2_mode == 3'd5 && !ca2_o && !data_acc && !ctrl_wr) |=> ca2_o); // R9
  AST_MANUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ca2_mode == 3'd6) |-> (!ca2_o && ca2_oe_o)); // R10
  AST_QUIET_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_acc && ca1_flag_o && !flag_clr_i[0]) |=> ca1_flag_o); // R11
  AST_OUTPUT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ca2_mode[2] |-> !ca2_set_o); // R12
endmodule

bind hspp_port hspp_port_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .data_acc(data_acc), .quiet_acc(quiet_acc),
  .ctrl_wr(ctrl_wr), .ca2_mode(ctrl_q[3:1]), .flag_clr_i(flag_clr_i),
  .ca1_set_o(ca1_set_o), .ca2_set_o(ca2_set_o), .ca1_flag_o(ca1_flag_o),
  .ca2_flag_o(ca2_flag_o), .ca2_o(ca2_o), .ca2_oe_o(ca2_oe_o), .lat_q(lat_q)
);

// File: tb/hspp_port_tb.sv
module hspp_port_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, cs_i, rw_i, ca1_i, ca2_i;
  logic [1:0]   rs_i, flag_clr_i;
  logic [W-1:0] wdata_i, rdata_o, pa_i, pa_o, pa_oe_o;
  logic         ca2_o, ca2_oe_o, ca1_set_o, ca2_set_o, ca1_flag_o, ca2_flag_o;
  logic [W-1:0] v;

  int n_chk = 0;
  int n_bad = 0;

  hspp_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .rw_i(rw_i), .rs_i(rs_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pa_i(pa_i), .pa_o(pa_o),
    .pa_oe_o(pa_oe_o), .ca1_i(ca1_i), .ca2_i(ca2_i), .ca2_o(ca2_o),
    .ca2_oe_o(ca2_oe_o), .flag_clr_i(flag_clr_i), .ca1_set_o(ca1_set_o),
    .ca2_set_o(ca2_set_o), .ca1_flag_o(ca1_flag_o), .ca2_flag_o(ca2_flag_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus access; returns at the falling edge after the access edge
  task automatic acc(input logic [1:0] sel, input logic rd, input logic [W-1:0] wd,
                     output logic [W-1:0] got);
    cs_i = 1'b1; rw_i = rd; rs_i = sel; wdata_i = wd;
    #2 got = rdata_o;
    @(posedge clk);
    #1 cs_i = 1'b0; rw_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] wd);
    logic [W-1:0] dummy;
    acc(sel, 1'b0, wd, dummy);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_flag(input logic [1:0] which);
    flag_clr_i = which;
    @(negedge clk);
    flag_clr_i = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired before the sequence ended");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_i = 1'b0; rw_i = 1'b1; rs_i = 2'd0; wdata_i = '0;
    pa_i = '0; ca1_i = 1'b1; ca2_i = 1'b1; flag_clr_i = 2'b00;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    acc(2'd1, 1'b1, '0, v); chk("R1 dir reg", v, 0);
    acc(2'd2, 1'b1, '0, v); chk("R1 ctrl reg", v, 0);
    chk("R1 pa_oe", pa_oe_o, 0);
    chk("R1 ca2_oe", ca2_oe_o, 0);
    chk("R1 flags", {ca1_flag_o, ca2_flag_o}, 0);

    // R2 / R11 direction, output and pin sweep
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] d, o, p, e;
      d = W'(i * 37 + 3);
      o = W'(i * 91) ^ 8'h5A;
      p = W'(i * 53 + 7);
      pa_i = p;
      wr(2'd1, d);
      wr(2'd3, o);
      for (int b = 0; b < W; b++) e[b] = d[b] ? o[b] : p[b];
      acc(2'd0, 1'b1, '0, v); chk("R2 port read mix", v, e);
      acc(2'd3, 1'b1, '0, v); chk("R11 alias read mix", v, e);
      chk("R2 pa_oe", pa_oe_o, d);
      chk("R2 pa_o", pa_o, o);
    end
    wr(2'd1, '0);

    // R3 falling CA1 edge (ctrl bit0 = 0)
    ca1_i = 1'b0;
    @(negedge clk);
    chk("R3 set pulse", ca1_set_o, 1);
    chk("R3 flag not yet", ca1_flag_o, 0);
    @(negedge clk);
    chk("R3 flag set", ca1_flag_o, 1);
    chk("R3 set pulse one cycle", ca1_set_o, 0);
    acc(2'd3, 1'b1, '0, v); chk("R11 alias keeps CA1 flag", ca1_flag_o, 1);
    acc(2'd0, 1'b1, '0, v); chk("R4 data read clears CA1", ca1_flag_o, 0);
    ca1_i = 1'b1; idle(3);
    chk("R3 rising ignored", ca1_flag_o, 0);

    // R3 rising select, R4 clear input
    wr(2'd2, 8'h01);
    ca1_i = 1'b0; idle(3);
    chk("R3 falling ignored", ca1_flag_o, 0);
    ca1_i = 1'b1; idle(3);
    chk("R3 rising sets", ca1_flag_o, 1);
    clr_flag(2'b01);
    chk("R4 clear input", ca1_flag_o, 0);
    ca1_i = 1'b0; idle(3);
    wr(2'd0, 8'h00);
    chk("R4 data write clears", ca1_flag_o, 0);

    // R5 input latch
    wr(2'd2, 8'h11);
    pa_i = 8'hA5; ca1_i = 1'b1;
    @(negedge clk);
    pa_i = 8'h3C;
    idle(3);
    acc(2'd3, 1'b1, '0, v); chk("R5 latched via alias", v, 8'hA5);
    acc(2'd0, 1'b1, '0, v); chk("R5 latched via data", v, 8'hA5);
    acc(2'd0, 1'b1, '0, v); chk("R5 live after clear", v, 8'h3C);
    wr(2'd2, 8'h00);

    // R6 / R7 CA2 input modes
    for (int m = 0; m < 4; m++) begin
      logic pos, ind;
      pos = m[1]; ind = m[0];
      wr(2'd2, W'(m << 1));
      ca2_i = pos; idle(3);
      clr_flag(2'b10);
      chk("R6 flag cleared", ca2_flag_o, 0);
      ca2_i = ~pos; idle(3);
      chk("R6 inactive edge ignored", ca2_flag_o, 0);
      ca2_i = pos;
      @(negedge clk);
      chk("R6 set pulse", ca2_set_o, 1);
      @(negedge clk);
      chk("R6 active edge sets", ca2_flag_o, 1);
      acc(2'd3, 1'b1, '0, v); chk("R11 alias keeps CA2", ca2_flag_o, 1);
      acc(2'd0, 1'b1, '0, v);
      if (ind) chk("R7 access keeps flag", ca2_flag_o, 1);
      else     chk("R6 access clears flag", ca2_flag_o, 0);
      clr_flag(2'b10);
      chk("R7 clear input", ca2_flag_o, 0);
      chk("R10 input mode oe low", ca2_oe_o, 0);
    end

    // R8..R12 output modes
    for (int m = 4; m < 8; m++) begin
      wr(2'd2, W'(m << 1));
      ca2_i = ~ca2_i; idle(3);
      ca2_i = ~ca2_i; idle(3);
      chk("R12 no flag in output mode", ca2_flag_o, 0);
      chk("R10 output mode oe high", ca2_oe_o, 1);
      case (m)
        4: begin
          chk("R8 idle high", ca2_o, 1);
          acc(2'd3, 1'b1, '0, v); chk("R11 alias no handshake", ca2_o, 1);
          acc(2'd0, 1'b1, '0, v); chk("R8 low after access", ca2_o, 0);
          idle(2); chk("R8 stays low", ca2_o, 0);
          ca1_i = 1'b0;
          @(negedge clk); chk("R8 low while edge seen", ca2_o, 0);
          @(negedge clk); chk("R8 high after CA1", ca2_o, 1);
          ca1_i = 1'b1; idle(2);
        end
        5: begin
          chk("R9 idle high", ca2_o, 1);
          wr(2'd0, 8'h00); chk("R9 strobe low", ca2_o, 0);
          @(negedge clk); chk("R9 strobe one cycle", ca2_o, 1);
          idle(2); chk("R9 stays high", ca2_o, 1);
          wr(2'd3, 8'h00); chk("R11 alias no strobe", ca2_o, 1);
        end
        6: chk("R10 manual low", ca2_o, 0);
        default: chk("R10 manual high", ca2_o, 1);
      endcase
    end

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule